// File: doc/BRIEF.md
# Scrolling display address generator

This block produces the video memory fetch address for a 200-line raster display that reads 40 bytes per line from each bitmap plane. A free-running counter advances by one on every active byte slot, holds through horizontal blanking and is cleared during vertical blanking. The result is that line `r`, byte `k` is fetched from address `r*40+k`. The block has no side-effects on memory and only computes addresses.

Hardware vertical scrolling works by address conversion. A window is set by a start register and an end register. Each register is counted in 64-byte units, where 5 units equal one 8-raster text row. A byte offset register, counted in 8-byte units, shifts every address inside the window, and addresses that pass the end of the window wrap back to its start. Because addresses above and below the window pass through unchanged, the screen can be split into a fixed top band, a scrolling middle band and a fixed bottom band. The CPU writes its data in the plain order, and the conversion alone moves the picture.

A character-mode select switches the counter to text fetching. In this mode one address serves a character cell for 8 consecutive rasters, and a 3-bit row counter selects the glyph line. The scroll registers are sampled only while vertical blanking is active, so a frame never tears.

Top module: `scroll_addr_gen`

## Requirements
- R1: After reset, `disp_addr` is 0 and `row_in_char` is 0.
- R2: In bitmap mode (`char_mode`=0) with an empty window or a zero offset, the address for line r, byte k is r*40+k, so the last byte of the frame is 7999.
- R3: In bitmap mode the counter does not move while `hblank` is 1, so during blanking after line r, `disp_addr` shows the converted value of (r+1)*40.
- R4: While `vblank` is 1 the counter and the row counter are cleared. From the second blanking cycle on, `disp_addr` is the converted value of 0 and `row_in_char` is 0.
- R5: In character mode, line r, byte k uses address (r/8)*40+k, and `row_in_char` equals r mod 8. Addresses run from 0 to 999, and the scroll registers have no effect.
- R6: In bitmap mode, with lo=`win_start`*64, hi=`win_end`*64 and off=`scroll_ofs`*8, an address A with lo<=A<hi becomes A+off, minus (hi-lo) when A+off>=hi. Converted addresses stay within [lo,hi).
- R7: Addresses below lo or at/above hi are output unchanged. This gives a split screen in which only the middle band scrolls.
- R8: `win_start`, `win_end` and `scroll_ofs` are captured only while `vblank` is 1. Changes during the active frame take effect from the next frame.
- R9: An offset of exactly hi-lo bytes gives an unchanged picture. Offsets larger than hi-lo, or `win_end` < `win_start`, are outside the contract.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte-slot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hblank | input | 1 | Horizontal blanking, 1 = blank |
| vblank | input | 1 | Vertical blanking, 1 = blank |
| char_mode | input | 1 | 1 = character fetch mode, 0 = bitmap mode |
| win_start | input | 7 | Scroll window start, 64-byte units |
| win_end | input | 7 | Scroll window end (exclusive), 64-byte units |
| scroll_ofs | input | 10 | Scroll offset, 8-byte units |
| disp_addr | output | 13 | Converted display memory address |
| row_in_char | output | 3 | Glyph line within a character cell |

## Verification
The bench targets the wrap point at the window end, the line that sits exactly on each window edge, and an offset equal to the full window span. A design that wrapped with the wrong span or compared against the wrong edge would fetch from outside the band, or leave a duplicated line at the seam.

Register writes are made in the middle of a frame. A design that did not defer them to vertical blanking would tear the picture at that line. In character mode the bench checks that the cell address repeats for exactly eight rasters. A design with an off-by-one row counter would either skip a text row or repeat one. The bench also checks the held value during horizontal blanking. A design that kept counting there would drift by the blanking length every line.

// File: rtl/scroll_addr_gen.sv
module scroll_addr_gen #(
  parameter int AW        = 13,
  parameter int WIN_W     = 7,
  parameter int OFS_W     = 10,
  parameter int WIN_SHIFT = 6,
  parameter int OFS_SHIFT = 3,
  parameter int ROW_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hblank,
  input  logic             vblank,
  input  logic             char_mode,
  input  logic [WIN_W-1:0] win_start,
  input  logic [WIN_W-1:0] win_end,
  input  logic [OFS_W-1:0] scroll_ofs,
  output logic [AW-1:0]    disp_addr,
  output logic [ROW_W-1:0] row_in_char
);
  localparam int XW = AW + 1;

  logic [AW-1:0]    cnt, line_base;
  logic [ROW_W-1:0] row;
  logic             hb_q;
  logic [WIN_W-1:0] lo_q, hi_q;
  logic [OFS_W-1:0] ofs_q;

  wire active  = ~hblank & ~vblank;
  wire hb_rise = hblank & ~hb_q & ~vblank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      line_base <= '0;
      row       <= '0;
      hb_q      <= 1'b0;
      lo_q      <= '0;
      hi_q      <= '0;
      ofs_q     <= '0;
    end else begin
      hb_q <= hblank;
      if (vblank) begin
        cnt       <= '0;
        line_base <= '0;
        row       <= '0;
        lo_q      <= win_start;
        hi_q      <= win_end;
        ofs_q     <= scroll_ofs;
      end else if (active) begin
        cnt <= cnt + 1'b1;
      end else if (hb_rise && char_mode) begin
        row <= row + 1'b1;
        if (row == '1) line_base <= cnt;
        else           cnt       <= line_base;
      end
    end
  end

  logic [XW-1:0] w_lo, w_hi, span, offs, sum, wrapped;
  logic          in_win;

  assign w_lo    = XW'(lo_q) << WIN_SHIFT;
  assign w_hi    = XW'(hi_q) << WIN_SHIFT;
  assign span    = w_hi - w_lo;
  assign offs    = XW'(ofs_q) << OFS_SHIFT;
  assign sum     = XW'(cnt) + offs;
  assign in_win  = (XW'(cnt) >= w_lo) && (XW'(cnt) < w_hi);
  assign wrapped = (sum >= w_hi) ? (sum - span) : sum;

  assign disp_addr   = (!char_mode && in_win) ? wrapped[AW-1:0] : cnt;
  assign row_in_char = row;

  AST_VB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    vblank |=> (cnt == '0 && row == '0)); // R4
  AST_HB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hblank && !vblank && !char_mode) |=> $stable(cnt)); // R3
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hb_rise && char_mode) |=> (row == ROW_W'($past(row) + 1'b1))); // R5
  AST_FRAME_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    !vblank |=> ($stable(lo_q) && $stable(hi_q) && $stable(ofs_q))); // R8
  AST_STAY_IN_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    (!char_mode && in_win && offs <= span)
      |-> ({1'b0, disp_addr} >= w_lo && {1'b0, disp_addr} < w_hi)); // R6
endmodule

// File: tb/sim_scroll_addr_gen.sv
module sim_scroll_addr_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hblank = 1'b0, vblank = 1'b1, char_mode = 1'b0;
  logic [6:0] win_start = '0, win_end = '0;
  logic [9:0] scroll_ofs = '0;
  logic [12:0] disp_addr;
  logic [2:0]  row_in_char;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  scroll_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .hblank(hblank), .vblank(vblank),
    .char_mode(char_mode), .win_start(win_start), .win_end(win_end),
    .scroll_ofs(scroll_ofs), .disp_addr(disp_addr), .row_in_char(row_in_char)
  );

  function automatic int xlate(int a, int s, int e, int o);
    int lo = s * 64;
    int hi = e * 64;
    int t;
    if (a >= lo && a < hi) begin
      t = a + o * 8;
      if (t >= hi) t = t - (hi - lo);
      return t;
    end
    return a;
  endfunction

  task automatic chk(string req, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      if (n_bad < 20) $display("FAIL %s: got %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic frame(string req, bit cm, int s, int e, int o, bit mid_change);
    int ad;
    @(negedge clk);
    vblank = 1'b1; hblank = 1'b0; char_mode = cm;
    win_start = 7'(s); win_end = 7'(e); scroll_ofs = 10'(o);
    for (int i = 0; i < 6; i++) begin
      if (i > 0) begin
        chk("R4 addr", disp_addr, cm ? 0 : xlate(0, s, e, o));
        chk("R4 row", row_in_char, 0);
      end
      @(negedge clk);
    end
    for (int r = 0; r < 200; r++) begin
      if (mid_change && r == 100) begin
        win_start = 7'($urandom % 128);
        win_end = 7'($urandom % 128);
        scroll_ofs = 10'($urandom % 1024);
      end
      for (int k = 0; k < 40; k++) begin
        vblank = 1'b0; hblank = 1'b0;
        #1;
        if (cm) begin
          chk("R5 addr", disp_addr, (r / 8) * 40 + k);
          chk("R5 row", row_in_char, r % 8);
        end else begin
          ad = r * 40 + k;
          chk(req, disp_addr, xlate(ad, s, e, o));
        end
        @(negedge clk);
      end
      for (int h = 0; h < 6; h++) begin
        hblank = 1'b1;
        #1;
        if (!cm && h > 0) chk("R3 hold", disp_addr, xlate((r + 1) * 40, s, e, o));
        @(negedge clk);
      end
    end
  endtask

  initial begin
    int s, e, o;
    void'($urandom(32'd4242));
    #9;
    @(negedge clk);
    chk("R1 addr", disp_addr, 0);
    chk("R1 row", row_in_char, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 addr after release", disp_addr, 0);

    frame("R2 plain", 1'b0, 0, 125, 0, 1'b0);
    frame("R6 one line", 1'b0, 0, 125, 5, 1'b0);
    frame("R6 eight lines", 1'b0, 0, 125, 40, 1'b0);
    frame("R7 split", 1'b0, 25, 90, 5, 1'b0);
    frame("R9 full span", 1'b0, 0, 125, 1000, 1'b0);
    frame("R5 text", 1'b1, 10, 60, 7, 1'b0);
    for (int n = 0; n < 3; n++) begin
      s = $urandom % 110;
      e = s + 1 + ($urandom % (125 - s));
      o = $urandom % ((e - s) * 8 + 1);
      frame("R8 random", 1'b0, s, e, o, 1'b1);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule